// File: doc/BRIEF.md
# Serial OSD Memory Write Decoder

This block is the receiving side of a three-wire serial link (data, clock, chip select) that fills an on-screen display controller's storage: a character page of 11 rows by 28 cells of 12-bit words, 11 row-attribute words, and 5 configuration registers. The three serial lines are brought into the system clock domain, bits are shifted in MSB first while chip select is low, and each chip-select frame is classified by the number of clock pulses it carried when chip select returns high.

A 16-bit frame carries a 4-bit code in its top bits. The code selects a pointer load, a full data write, an oscillator stop or a device reset. An 8-bit frame is a short data write that keeps the upper nibble of the previous full write. A frame with no clocks repeats the last written word. Each data write is issued as a one-cycle strobe, to the page, the attribute store or one register, and the write pointer then advances by the rule its 2-bit structure field selects. Callers attach the storage arrays and register shadows to the strobes.

Top module: `osd_ser_loader`

## Requirements
- R1: A 16-bit frame with bits 15:12 = 0000 and bit 5 = 0 loads the pointer: row/buffer from bits 11:8, structure from bits 7:6, cell index from bits 4:0. It emits no strobe.
- R2: A 16-bit frame with bits 15:12 = 0001 writes bits 11:0 at the pointer, and the pointer then advances.
- R3: An 8-bit frame writes {upper nibble of the most recent 16-bit data write, the 8 received bits} at the pointer, and the pointer then advances.
- R4: A frame with zero clocks writes the last data word again at the pointer, and the pointer then advances.
- R5: Structure 00 addresses the page. After cell 27 the pointer goes to cell 0 of the next row, and after row 10 it goes to row 0.
- R6: Structure 01 addresses the page. After cell 27 the pointer returns to cell 0 of the same row.
- R7: Structure 11 with buffer 0 addresses attribute words at index 0–10 (attr_we) and registers at index 12–16 (reg_we bit index−12). Any other location produces no strobe, but the pointer still increments by one.
- R8: A 16-bit frame with code 0010 clears osc_run. Code 0011 pulses rst_pulse, sets osc_run, and clears the pointer and the last data word.
- R9: Frames of any length other than 0, 8 or 16 bits, 16-bit frames with codes 0100–1111, and address frames with bit 5 set all leave the pointer and the data word unchanged and emit no strobe.
- R10: Serial clock edges while chip select is high do not shift data.
- R11: Every strobe lasts one system cycle. At most one of page_we, attr_we, reg_we and rst_pulse is active at a time.
- R12: After system reset no strobe is active, osc_run is 1, the pointer is at page row 0 cell 0 with structure 00, and the last data word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_csn | input | 1 | Serial chip select, active low |
| ser_data | input | 1 | Serial data, MSB first |
| page_we | output | 1 | Page cell write strobe |
| page_row | output | 4 | Page row of the last page write |
| page_col | output | 5 | Page cell of the last page write |
| attr_we | output | 1 | Row attribute write strobe |
| attr_idx | output | 4 | Attribute index of the last attribute write |
| reg_we | output | 5 | One-hot register write strobe |
| wr_data | output | 12 | Data word of the last write |
| rst_pulse | output | 1 | One-cycle device reset request |
| osc_run | output | 1 | Oscillator run request level |

## Verification
A level change on the serial lines passes through two synchronizer stages, an edge-detect and frame register, and an output register. A strobe therefore appears on the fourth system clock edge after chip select is seen high, and osc_run changes on that same edge. The bench holds chip select high for twelve cycles after each frame. A monitor samples on falling clock edges and records every strobe cycle, together with its address fields and data. Each check compares that record, the strobe-cycle count and osc_run only after the window has closed. Dropped frames are judged by what a following write shows.

// File: rtl/osd_ser_pkg.sv
`timescale 1ns/1ps
package osd_ser_pkg;

    localparam int FRAME_W   = 16;
    localparam int BYTE_W    = 8;
    localparam int DATA_W    = 12;
    localparam int ROW_W     = 4;
    localparam int COL_W     = 5;
    localparam int ROW_LAST  = 10;
    localparam int COL_LAST  = 27;
    localparam int ATTR_LAST = 10;
    localparam int REG_BASE  = 12;
    localparam int REG_N     = 5;
    localparam int CNT_W     = $clog2(FRAME_W + 2);
    localparam int CNT_SAT   = FRAME_W + 1;

    typedef enum logic [2:0] {
        FK_NONE,
        FK_ADDR,
        FK_DATA16,
        FK_DATA8,
        FK_REPEAT,
        FK_STOP,
        FK_RESET
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e          kind;
        logic [DATA_W-1:0]    body;
    } frame_t;

    typedef enum logic [1:0] {
        ST_PAGE_SEQ = 2'b00,
        ST_PAGE_ROW = 2'b01,
        ST_SPARE    = 2'b10,
        ST_REGS     = 2'b11
    } stru_e;

    typedef struct packed {
        stru_e              stru;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   depl;
    } wptr_t;

    function automatic frame_kind_e classify(input logic [CNT_W-1:0] cnt,
                                             input logic [FRAME_W-1:0] w);
        frame_kind_e k;
        k = FK_NONE;
        if (cnt == '0) begin
            k = FK_REPEAT;
        end else if (cnt == CNT_W'(BYTE_W)) begin
            k = FK_DATA8;
        end else if (cnt == CNT_W'(FRAME_W)) begin
            case (w[15:12])
                4'h0:    k = w[5] ? FK_NONE : FK_ADDR;
                4'h1:    k = FK_DATA16;
                4'h2:    k = FK_STOP;
                4'h3:    k = FK_RESET;
                default: k = FK_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic wptr_t advance(input wptr_t p);
        wptr_t n;
        n = p;
        if (p.stru == ST_PAGE_SEQ || p.stru == ST_PAGE_ROW) begin
            if (p.depl >= COL_W'(COL_LAST)) begin
                n.depl = '0;
                if (p.stru == ST_PAGE_SEQ)
                    n.row = (p.row >= ROW_W'(ROW_LAST)) ? '0 : p.row + 1'b1;
            end else begin
                n.depl = p.depl + 1'b1;
            end
        end else begin
            n.depl = p.depl + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/osd_ser_sync.sv
`timescale 1ns/1ps
module osd_ser_sync #(
    parameter int         STAGES = 2,
    parameter int         N      = 3,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst)
                chain <= {STAGES{INIT[b]}};
            else
                chain <= {chain[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/osd_ser_frame.sv
`timescale 1ns/1ps
module osd_ser_frame
    import osd_ser_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_s,
    input  logic   csn_s,
    input  logic   data_s,
    output logic   frame_v,
    output frame_t frame
);
    logic               sclk_q;
    logic               csn_q;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               csn_fall;
    logic               csn_rise;
    logic               sclk_rise;

    assign csn_fall  = csn_q & ~csn_s;
    assign csn_rise  = ~csn_q & csn_s;
    assign sclk_rise = ~sclk_q & sclk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            csn_q   <= 1'b1;
            shreg   <= '0;
            cnt     <= '0;
            frame_v <= 1'b0;
            frame   <= '{kind: FK_NONE, body: '0};
        end else begin
            sclk_q  <= sclk_s;
            csn_q   <= csn_s;
            frame_v <= 1'b0;
            if (csn_fall) begin
                shreg <= '0;
                cnt   <= '0;
            end else if (!csn_s && sclk_rise) begin
                shreg <= {shreg[FRAME_W-2:0], data_s};
                if (cnt != CNT_W'(CNT_SAT))
                    cnt <= cnt + 1'b1;
            end
            if (csn_rise) begin
                frame_v    <= 1'b1;
                frame.kind <= classify(cnt, shreg);
                frame.body <= shreg[DATA_W-1:0];
            end
        end
    end
endmodule

// File: rtl/osd_ser_ptr.sv
`timescale 1ns/1ps
module osd_ser_ptr
    import osd_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_v,
    input  frame_t            frame,
    output logic              page_we,
    output logic [ROW_W-1:0]  page_row,
    output logic [COL_W-1:0]  page_col,
    output logic              attr_we,
    output logic [ROW_W-1:0]  attr_idx,
    output logic [REG_N-1:0]  reg_we,
    output logic [DATA_W-1:0] wr_data,
    output logic              rst_pulse,
    output logic              osc_run
);
    wptr_t             ptr;
    logic [DATA_W-1:0] last_data;
    logic [DATA_W-1:0] wdata;
    logic              is_write;
    logic              page_hit;
    logic              regs_space;
    logic              attr_hit;
    logic [REG_N-1:0]  reg_sel;

    always_comb begin
        unique case (frame.kind)
            FK_DATA16: wdata = frame.body;
            FK_DATA8:  wdata = {last_data[DATA_W-1:BYTE_W], frame.body[BYTE_W-1:0]};
            default:   wdata = last_data;
        endcase
    end

    assign is_write   = frame_v && (frame.kind == FK_DATA16 ||
                                    frame.kind == FK_DATA8  ||
                                    frame.kind == FK_REPEAT);
    assign page_hit   = (ptr.stru == ST_PAGE_SEQ || ptr.stru == ST_PAGE_ROW) &&
                        (ptr.row <= ROW_W'(ROW_LAST)) && (ptr.depl <= COL_W'(COL_LAST));
    assign regs_space = (ptr.stru == ST_REGS) && (ptr.row == '0);
    assign attr_hit   = regs_space && (ptr.depl <= COL_W'(ATTR_LAST));

    for (genvar i = 0; i < REG_N; i++) begin : g_regsel
        assign reg_sel[i] = regs_space && (ptr.depl == COL_W'(REG_BASE + i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '{stru: ST_PAGE_SEQ, row: '0, depl: '0};
            last_data <= '0;
            page_we   <= 1'b0;
            page_row  <= '0;
            page_col  <= '0;
            attr_we   <= 1'b0;
            attr_idx  <= '0;
            reg_we    <= '0;
            wr_data   <= '0;
            rst_pulse <= 1'b0;
            osc_run   <= 1'b1;
        end else begin
            page_we   <= 1'b0;
            attr_we   <= 1'b0;
            reg_we    <= '0;
            rst_pulse <= 1'b0;
            if (is_write) begin
                last_data <= wdata;
                wr_data   <= wdata;
                ptr       <= advance(ptr);
                if (page_hit) begin
                    page_we  <= 1'b1;
                    page_row <= ptr.row;
                    page_col <= ptr.depl;
                end
                if (attr_hit) begin
                    attr_we  <= 1'b1;
                    attr_idx <= ptr.depl[ROW_W-1:0];
                end
                reg_we <= reg_sel;
            end else if (frame_v) begin
                case (frame.kind)
                    FK_ADDR: begin
                        ptr.stru <= stru_e'(frame.body[7:6]);
                        ptr.row  <= frame.body[11:8];
                        ptr.depl <= frame.body[4:0];
                    end
                    FK_STOP:  osc_run <= 1'b0;
                    FK_RESET: begin
                        rst_pulse <= 1'b1;
                        osc_run   <= 1'b1;
                        ptr       <= '{stru: ST_PAGE_SEQ, row: '0, depl: '0};
                        last_data <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/osd_ser_loader.sv
`timescale 1ns/1ps
module osd_ser_loader
    import osd_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_clk,
    input  logic          ser_csn,
    input  logic          ser_data,
    output logic          page_we,
    output logic [3:0]    page_row,
    output logic [4:0]    page_col,
    output logic          attr_we,
    output logic [3:0]    attr_idx,
    output logic [4:0]    reg_we,
    output logic [11:0]   wr_data,
    output logic          rst_pulse,
    output logic          osc_run
);
    localparam int LINES = 3;
    localparam logic [LINES-1:0] LINE_INIT = 3'b010;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    logic             frame_v;
    frame_t           frame;

    assign raw_lines = {ser_data, ser_csn, ser_clk};

    osd_ser_sync #(
        .STAGES (SYNC_STAGES),
        .N      (LINES),
        .INIT   (LINE_INIT)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    osd_ser_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sync_lines[0]),
        .csn_s   (sync_lines[1]),
        .data_s  (sync_lines[2]),
        .frame_v (frame_v),
        .frame   (frame)
    );

    osd_ser_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .frame_v   (frame_v),
        .frame     (frame),
        .page_we   (page_we),
        .page_row  (page_row),
        .page_col  (page_col),
        .attr_we   (attr_we),
        .attr_idx  (attr_idx),
        .reg_we    (reg_we),
        .wr_data   (wr_data),
        .rst_pulse (rst_pulse),
        .osc_run   (osc_run)
    );
endmodule

// File: rtl/osd_ser_loader_chk.sv
`timescale 1ns/1ps
module osd_ser_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       ser_csn,
    input logic       page_we,
    input logic [3:0] page_row,
    input logic [4:0] page_col,
    input logic       attr_we,
    input logic [3:0] attr_idx,
    input logic [4:0] reg_we,
    input logic       rst_pulse,
    input logic       osc_run
);
    logic any_strobe;
    assign any_strobe = page_we | attr_we | (|reg_we) | rst_pulse;

    p_one_target_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({page_we, attr_we, |reg_we, rst_pulse}) && $onehot0(reg_we))
        else $error("R11 more than one strobe active");

    p_single_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        any_strobe |=> !any_strobe)
        else $error("R11 strobe longer than one cycle");

    p_page_range_r5: assert property (@(posedge clk) disable iff (rst)
        page_we |-> (page_row <= 4'd10 && page_col <= 5'd27))
        else $error("R5 page write outside the page");

    p_attr_range_r7: assert property (@(posedge clk) disable iff (rst)
        attr_we |-> attr_idx <= 4'd10)
        else $error("R7 attribute index out of range");

    p_reset_runs_r8: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> osc_run)
        else $error("R8 reset message left oscillator stopped");

    p_strobe_after_frame_r10: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> ser_csn)
        else $error("R10 strobe while chip select low");
endmodule

bind osd_ser_loader osd_ser_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_csn   (ser_csn),
    .page_we   (page_we),
    .page_row  (page_row),
    .page_col  (page_col),
    .attr_we   (attr_we),
    .attr_idx  (attr_idx),
    .reg_we    (reg_we),
    .rst_pulse (rst_pulse),
    .osc_run   (osc_run)
);

// File: tb/osd_ser_loader_test.sv
`timescale 1ns/1ps
module osd_ser_loader_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_csn = 1'b1;
    logic        ser_data = 1'b0;
    logic        page_we;
    logic [3:0]  page_row;
    logic [4:0]  page_col;
    logic        attr_we;
    logic [3:0]  attr_idx;
    logic [4:0]  reg_we;
    logic [11:0] wr_data;
    logic        rst_pulse;
    logic        osc_run;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    osd_ser_loader uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_data(ser_data),
        .page_we(page_we), .page_row(page_row), .page_col(page_col),
        .attr_we(attr_we), .attr_idx(attr_idx), .reg_we(reg_we),
        .wr_data(wr_data), .rst_pulse(rst_pulse), .osc_run(osc_run)
    );

    // kind: 0 none, 1 page (row,col), 2 attribute (row=index), 3 register (col=bit), 4 reset
    typedef struct packed {
        logic [4:0]  nbits;
        logic [15:0] word;
        logic [2:0]  kind;
        logic [3:0]  row;
        logic [4:0]  col;
        logic [11:0] data;
        logic        osc;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t TBL [NV] = '{
        '{5'd0,  16'h0000, 3'd1, 4'd0,  5'd0,  12'h000, 1'b1}, // R12 R4 reset pointer/data
        '{5'd16, 16'h0019, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R1 load r0 c25
        '{5'd16, 16'h1ABC, 3'd1, 4'd0,  5'd25, 12'hABC, 1'b1}, // R2
        '{5'd8,  16'h005D, 3'd1, 4'd0,  5'd26, 12'hA5D, 1'b1}, // R3
        '{5'd0,  16'h0000, 3'd1, 4'd0,  5'd27, 12'hA5D, 1'b1}, // R4
        '{5'd8,  16'h0007, 3'd1, 4'd1,  5'd0,  12'hA07, 1'b1}, // R5 next row
        '{5'd16, 16'h0A1B, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R1 r10 c27
        '{5'd16, 16'h1123, 3'd1, 4'd10, 5'd27, 12'h123, 1'b1}, // R2
        '{5'd0,  16'h0000, 3'd1, 4'd0,  5'd0,  12'h123, 1'b1}, // R5 wrap to row 0
        '{5'd16, 16'h035B, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R1 structure 01 r3 c27
        '{5'd16, 16'h1456, 3'd1, 4'd3,  5'd27, 12'h456, 1'b1}, // R6
        '{5'd8,  16'h0099, 3'd1, 4'd3,  5'd0,  12'h499, 1'b1}, // R6 same row
        '{5'd16, 16'h00CA, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R7 attribute 10
        '{5'd16, 16'h1777, 3'd2, 4'd10, 5'd0,  12'h777, 1'b1}, // R7
        '{5'd0,  16'h0000, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R7 gap at 11
        '{5'd16, 16'h1888, 3'd3, 4'd0,  5'd0,  12'h888, 1'b1}, // R7 register 12
        '{5'd8,  16'h0011, 3'd3, 4'd0,  5'd1,  12'h811, 1'b1}, // R7 R3
        '{5'd0,  16'h0000, 3'd3, 4'd0,  5'd2,  12'h811, 1'b1}, // R7
        '{5'd0,  16'h0000, 3'd3, 4'd0,  5'd3,  12'h811, 1'b1}, // R7
        '{5'd0,  16'h0000, 3'd3, 4'd0,  5'd4,  12'h811, 1'b1}, // R7 register 16
        '{5'd0,  16'h0000, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R7 beyond 16
        '{5'd12, 16'h0FFF, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R9 odd length
        '{5'd16, 16'h5FFF, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R9 unused code
        '{5'd16, 16'h0000, 3'd0, 4'd0,  5'd0,  12'h000, 1'b1}, // R1 r0 c0
        '{5'd0,  16'h0000, 3'd1, 4'd0,  5'd0,  12'h811, 1'b1}, // R9 data survived
        '{5'd16, 16'h2000, 3'd0, 4'd0,  5'd0,  12'h000, 1'b0}, // R8 stop
        '{5'd16, 16'h3000, 3'd4, 4'd0,  5'd0,  12'h000, 1'b1}, // R8 reset
        '{5'd0,  16'h0000, 3'd1, 4'd0,  5'd0,  12'h000, 1'b1}  // R8 cleared state
    };

    // strobe monitor, sampled between edges
    int          cap_n;
    logic [2:0]  cap_kind;
    logic [3:0]  cap_row;
    logic [4:0]  cap_col;
    logic [11:0] cap_data;

    task automatic cap_clear();
        cap_n = 0; cap_kind = 0; cap_row = 0; cap_col = 0; cap_data = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (page_we) begin
                cap_n++; cap_kind = 3'd1; cap_row = page_row; cap_col = page_col; cap_data = wr_data;
            end
            if (attr_we) begin
                cap_n++; cap_kind = 3'd2; cap_row = attr_idx; cap_data = wr_data;
            end
            if (|reg_we) begin
                cap_n++; cap_kind = 3'd3; cap_data = wr_data;
                for (int i = 0; i < 5; i++) if (reg_we[i]) cap_col = 5'(i);
            end
            if (rst_pulse) begin
                cap_n++; cap_kind = 3'd4;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int n, input logic [15:0] w);
        cap_clear();
        ser_csn = 1'b0;
        cyc(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            cyc(3);
            ser_clk = 1'b1;
            cyc(3);
            ser_clk = 1'b0;
        end
        cyc(3);
        ser_csn = 1'b1;
        cyc(12);
    endtask

    task automatic expect_write(input string tag, input logic [2:0] kind, input logic [3:0] row,
                                input logic [4:0] col, input logic [11:0] data, input logic osc);
        logic [31:0] act, exp;
        act = {cap_n[3:0], cap_kind, cap_row, cap_col, cap_data, osc_run, 3'b0};
        exp = {(kind != 0) ? 4'd1 : 4'd0, kind, row, col, data, osc, 3'b0};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual n=%0d kind=%0d row=%0d col=%0d data=%h osc=%b expected n=%0d kind=%0d row=%0d col=%0d data=%h osc=%b",
                     tag, cap_n, cap_kind, cap_row, cap_col, cap_data, osc_run,
                     (kind != 0) ? 1 : 0, kind, row, col, data, osc);
        end
    endtask

    initial begin
        cap_clear();
        cyc(5);
        rst = 1'b0;
        cyc(8);
        // R12 reset state at the ports
        checks++;
        if ({page_we, attr_we, reg_we, rst_pulse, osc_run} !== 9'b0_0_00000_0_1) begin
            errors++;
            $display("FAIL R12: actual strobes/osc=%b expected 000000001",
                     {page_we, attr_we, reg_we, rst_pulse, osc_run});
        end

        for (int v = 0; v < NV; v++) begin
            send(int'(TBL[v].nbits), TBL[v].word);
            expect_write($sformatf("vector %0d", v), TBL[v].kind, TBL[v].row,
                         TBL[v].col, TBL[v].data, TBL[v].osc);
        end

        // R10: clock pulses with chip select high shift nothing; pointer is at r0 c1
        cap_clear();
        for (int i = 0; i < 8; i++) begin
            ser_data = 1'b1; cyc(3); ser_clk = 1'b1; cyc(3); ser_clk = 1'b0;
        end
        cyc(12);
        expect_write("R10 idle clocks", 3'd0, 4'd0, 5'd0, 12'h000, 1'b1);
        send(16, 16'h1321);
        expect_write("R10 R2 after idle clocks", 3'd1, 4'd0, 5'd1, 12'h321, 1'b1);

        // R9: address frame with bit 5 set is dropped; pointer stays at r0 c2
        send(16, 16'h0025);
        expect_write("R9 bit5 address", 3'd0, 4'd0, 5'd0, 12'h000, 1'b1);
        send(0, 16'h0000);
        expect_write("R9 pointer kept", 3'd1, 4'd0, 5'd2, 12'h321, 1'b1);

        // R1 R11: attribute 0 via structure 11, single-cycle strobe
        send(16, 16'h00C0);
        send(16, 16'h1ACE);
        expect_write("R11 attr single strobe", 3'd2, 4'd0, 5'd0, 12'hACE, 1'b1);

        // R12: system reset mid-stream restores pointer and data
        rst = 1'b1; cyc(3); rst = 1'b0; cyc(6);
        send(0, 16'h0000);
        expect_write("R12 after system reset", 3'd1, 4'd0, 5'd0, 12'h000, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule